// File: doc/BRIEF.md
# UART Receiver with Fill-Level Interrupt and Address Filter

This block turns an asynchronous serial line into characters. It watches the line for a falling edge and confirms it as a start bit at the middle of the bit. It then takes eight or nine data bits, least significant first, and a stop bit, sampling each bit once at its centre. A baud tick input marks sixteen sampling slots per bit. Completed characters go into a four-entry first-in first-out store. Software reads the oldest character from that store and removes it with a one-cycle pop strobe.

An interrupt pulse is raised when a character enters the store. A two-bit mode sets the condition: every arrival, the arrival that brings the store to three characters, or the arrival that fills it. In nine-bit operation an optional filter discards characters whose top bit is clear until a character with the top bit set has been stored. This lets a receiver on a shared line ignore traffic meant for other stations.

The block also reports three conditions. An overrun flag is set when a character arrives while the store is full, and software clears it. Each stored character carries a framing-error bit. An idle flag shows when no frame is in progress.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset, idle is 1, data_avail is 0, overrun is 0 and rx_irq is 0.
- R2: A frame is a low start bit, then 8 data bits (nine_bit_en=0) or 9 data bits (nine_bit_en=1) sent LSB first, then a stop bit. Each bit lasts 16 baud ticks and is sampled near its middle. In 8-bit frames rd_data[8] reads 0. A low pulse shorter than half a bit is not taken as a start bit and stores nothing.
- R3: Up to four characters are held and read out oldest first on rd_data. A pop strobe removes the oldest one. data_avail is 1 exactly when at least one character is held. A pop while the store is empty has no effect.
- R4: With irq_mode[1]=0, rx_irq pulses for one cycle each time a character enters the store.
- R5: With irq_mode=2'b10, rx_irq pulses only when an arriving character brings the store to three characters.
- R6: With irq_mode=2'b11, rx_irq pulses only when an arriving character brings the store to four characters.
- R7: With nine_bit_en=1 and addr_det_en=1, a frame whose bit 8 is 0 is discarded, unless a frame with bit 8 = 1 has already been stored since the filter was last switched on. That address frame is stored, and later frames with bit 8 = 0 are stored too.
- R8: With nine_bit_en=0, addr_det_en has no effect: every frame is stored.
- R9: If a frame completes while four characters are held, overrun becomes 1 and the frame is discarded. Every frame that completes while overrun is 1 is discarded. A one-cycle ovr_clr strobe returns overrun to 0.
- R10: If the stop bit samples low, the character is still stored, and rd_ferr reads 1 while that character is at the head of the store. Otherwise rd_ferr reads 0.
- R11: idle is 0 while a frame is being received and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Sampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| nine_bit_en | input | 1 | 1 selects 9 data bits per frame |
| addr_det_en | input | 1 | Enables the address filter in 9-bit operation |
| irq_mode | input | 2 | Interrupt fill condition: 0x any, 10 three, 11 four |
| pop | input | 1 | Removes the oldest character |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 9 | Oldest held character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| data_avail | output | 1 | At least one character is held |
| overrun | output | 1 | A frame was lost because the store was full |
| idle | output | 1 | No frame in progress |
| rx_irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong sample counter or bit index shows up at the ports as a shifted or mis-ordered character on rd_data, as soon as the first frame is stored. A missed confirmation of the start bit shows up the same way. A store pointer or level that has drifted corrupts the order of characters, or data_avail, within one read-out of a filled store. Interrupt level bugs show up as a wrong count of rx_irq pulses across a sequence of arrivals. A stale address-filter or overrun state is exposed by the next frame that arrives, which is stored or dropped against expectation.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  localparam logic [1:0] IRQ_THREE_Q = 2'b10;
  localparam logic [1:0] IRQ_FULL    = 2'b11;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               rxd,
  input  logic               nine_bit,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_ferr,
  output logic               idle
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               valid_q, valid_d;
  logic [FRAME_W-1:0] data_q, data_d;
  logic               ferr_q, ferr_d;
  logic [IDX_W-1:0]   last_idx;

  assign last_idx = nine_bit ? IDX_W'(FRAME_W-1) : IDX_W'(FRAME_W-2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    valid_d = 1'b0;
    data_d  = data_q;
    ferr_d  = ferr_q;
    if (baud_tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rxd) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_FULL) begin
            cnt_d   = '0;
            shreg_d = {rxd, shreg_q[FRAME_W-1:1]};
            if (idx_q == last_idx) begin
              state_d = RX_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_FULL) begin
            cnt_d   = '0;
            valid_d = 1'b1;
            ferr_d  = !rxd;
            data_d  = nine_bit ? shreg_q : {1'b0, shreg_q[FRAME_W-1:1]};
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  always_ff @(posedge clk) begin
    shreg_q <= shreg_d;
    data_q  <= data_d;
  end

  assign frame_valid = valid_q;
  assign frame_data  = data_q;
  assign frame_ferr  = ferr_q;
  assign idle        = (state_q == RX_IDLE);

  AST_BUSY_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(!rxd && baud_tick)) else $error("busy without low line"); // R11

  AST_FRAME_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> idle) else $error("frame done while busy"); // R11

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty,
  output logic                         pop_ok
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  assign empty  = (lvl_q == '0);
  assign full   = (lvl_q == LVL_W'(DEPTH));
  assign pop_ok = pop && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (push) begin
      wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    end
    if (pop_ok) begin
      rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    end
    case ({push, pop_ok})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wptr_q == PTR_W'(i))) begin
        mem[i] <= wdata;
      end
    end
  end

  assign rdata = mem[rptr_q];
  assign level = lvl_q;

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full store"); // R9

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty) else $error("pop on empty changed level"); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)) else $error("level beyond depth"); // R3

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop_ok,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [1:0]                 mode,
  output logic                       irq
);

  localparam int LVL_W = $clog2(DEPTH+1);
  localparam logic [LVL_W-1:0] LVL_3Q   = LVL_W'((DEPTH*3)/4);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_after;
  logic             irq_d, irq_q;

  assign lvl_after = level + LVL_W'(push) - LVL_W'(pop_ok);

  always_comb begin
    irq_d = 1'b0;
    if (push) begin
      if (!mode[1]) begin
        irq_d = 1'b1;
      end else if (mode == IRQ_THREE_Q) begin
        irq_d = (lvl_after == LVL_3Q);
      end else begin
        irq_d = (lvl_after == LVL_FULL);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_IRQ_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(push)) else $error("interrupt without arrival"); // R4

  AST_IRQ_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(mode) == IRQ_FULL) |-> ($past(lvl_after) == LVL_FULL)) else $error("full interrupt early"); // R6

endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              nine_bit_en,
  input  logic              addr_det_en,
  input  logic [1:0]        irq_mode,
  input  logic              pop,
  input  logic              ovr_clr,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              data_avail,
  output logic              overrun,
  output logic              idle,
  output logic              rx_irq
);

  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int ENT_W = $bits(rx_char_t);

  logic rst_m, rst_int_n;
  logic rxd_m, rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m     <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m     <= 1'b1;
      rst_int_n <= rst_m;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  logic              frame_valid, frame_ferr;
  logic [CHAR_W-1:0] frame_data;

  uart_rx_deser #(.OVS(OVS), .FRAME_W(CHAR_W)) i_deser (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .baud_tick  (baud_tick),
    .rxd        (rxd_s),
    .nine_bit   (nine_bit_en),
    .frame_valid(frame_valid),
    .frame_data (frame_data),
    .frame_ferr (frame_ferr),
    .idle       (idle)
  );

  logic filt_on, accept, push, ovr_set;
  logic seen_q, seen_d, ovr_q, ovr_d;
  logic full, empty, pop_ok;
  logic [LVL_W-1:0] level;
  rx_char_t wr_ent, rd_ent;
  logic [ENT_W-1:0] rd_bits;

  assign filt_on = nine_bit_en && addr_det_en;
  assign accept  = frame_valid && (!filt_on || frame_data[CHAR_W-1] || seen_q);
  assign push    = accept && !full && !ovr_q;
  assign ovr_set = accept && (full || ovr_q);

  always_comb begin
    seen_d = seen_q;
    if (!filt_on) begin
      seen_d = 1'b0;
    end else if (push && frame_data[CHAR_W-1]) begin
      seen_d = 1'b1;
    end
    ovr_d = ovr_q;
    if (ovr_set) begin
      ovr_d = 1'b1;
    end else if (ovr_clr) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      seen_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      ovr_q  <= ovr_d;
    end
  end

  assign wr_ent.ferr = frame_ferr;
  assign wr_ent.data = frame_data;

  uart_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push),
    .wdata (wr_ent),
    .pop   (pop),
    .rdata (rd_bits),
    .level (level),
    .full  (full),
    .empty (empty),
    .pop_ok(pop_ok)
  );

  uart_rx_irq #(.DEPTH(DEPTH)) i_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push),
    .pop_ok(pop_ok),
    .level (level),
    .mode  (irq_mode),
    .irq   (rx_irq)
  );

  assign rd_ent     = rx_char_t'(rd_bits);
  assign rd_data    = rd_ent.data;
  assign rd_ferr    = rd_ent.ferr;
  assign data_avail = !empty;
  assign overrun    = ovr_q;

  AST_OVR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(overrun) |-> $past(frame_valid)) else $error("overrun without frame"); // R9

  AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (overrun && !ovr_clr) |=> overrun) else $error("overrun dropped by itself"); // R9

  AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_valid && filt_on && !frame_data[CHAR_W-1] && !seen_q) |=> $stable(level)) else $error("filtered frame stored"); // R7

endmodule

// File: tb/test_uart_rx_addr.sv
`timescale 1ns/1ps
module test_uart_rx_addr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       rxd;
  logic       nine_bit_en, addr_det_en;
  logic [1:0] irq_mode;
  logic       pop, ovr_clr;
  logic [8:0] rd_data;
  logic       rd_ferr, data_avail, overrun, idle, rx_irq;

  int total = 0;
  int bad   = 0;
  int irq_cnt = 0;
  logic idle_mid;

  localparam int BITCLK = 32;

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    baud_tick = ~baud_tick;
  end

  always @(posedge clk) if (rx_irq === 1'b1) irq_cnt <= irq_cnt + 1;

  uart_rx_addr i_uart_rx_addr (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en), .irq_mode(irq_mode),
    .pop(pop), .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .data_avail(data_avail), .overrun(overrun), .idle(idle), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic stop_ok);
    int nb;
    nb = nine ? 9 : 8;
    hold(1'b0, BITCLK);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (BITCLK/2) @(negedge clk);
      if (i == 2) idle_mid = idle;
      repeat (BITCLK/2) @(negedge clk);
    end
    if (stop_ok) hold(1'b1, BITCLK);
    else begin
      hold(1'b0, 24);
      hold(1'b1, BITCLK - 24);
    end
    hold(1'b1, 48);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 idle", idle, 1);
    check("R1 data_avail", data_avail, 0);
    check("R1 overrun", overrun, 0);
    check("R1 rx_irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    int base;
    irq_mode = 2'b00; nine_bit_en = 0; addr_det_en = 0;
    base = irq_cnt;
    send(9'h0A5, 0, 1);
    check("R11 busy mid frame", idle_mid, 0);
    check("R11 idle after frame", idle, 1);
    check("R3 avail", data_avail, 1);
    check("R2 8-bit data", rd_data, 9'h0A5);
    check("R10 no ferr", rd_ferr, 0);
    check("R4 irq per char", irq_cnt - base, 1);
    do_pop();
    check("R3 avail after pop", data_avail, 0);
    do_pop();
    check("R3 empty pop", data_avail, 0);
    send(9'h03C, 0, 1);
    check("R3 data after empty pop", rd_data, 9'h03C);
    check("R4 irq second char", irq_cnt - base, 2);
    do_pop();
  endtask

  task automatic t_nine();
    nine_bit_en = 1;
    send(9'h1C3, 1, 1);
    check("R2 9-bit data", rd_data, 9'h1C3);
    do_pop();
    nine_bit_en = 0;
  endtask

  task automatic t_mode_three();
    int base;
    irq_mode = 2'b10;
    base = irq_cnt;
    send(9'h011, 0, 1);
    send(9'h022, 0, 1);
    check("R5 no irq at two", irq_cnt - base, 0);
    send(9'h033, 0, 1);
    check("R5 irq at three", irq_cnt - base, 1);
    send(9'h044, 0, 1);
    check("R5 no irq at four", irq_cnt - base, 1);
    check("R3 order 1", rd_data, 9'h011); do_pop();
    check("R3 order 2", rd_data, 9'h022); do_pop();
    check("R3 order 3", rd_data, 9'h033); do_pop();
    check("R3 order 4", rd_data, 9'h044); do_pop();
    check("R3 drained", data_avail, 0);
  endtask

  task automatic t_full_overrun();
    int base;
    irq_mode = 2'b11;
    base = irq_cnt;
    send(9'h051, 0, 1);
    send(9'h052, 0, 1);
    send(9'h053, 0, 1);
    check("R6 no irq at three", irq_cnt - base, 0);
    send(9'h054, 0, 1);
    check("R6 irq at four", irq_cnt - base, 1);
    check("R9 no overrun yet", overrun, 0);
    send(9'h055, 0, 1);
    check("R9 overrun set", overrun, 1);
    check("R6 no irq on lost char", irq_cnt - base, 1);
    for (int k = 0; k < 4; k++) begin
      check("R9 kept chars", rd_data, 9'h051 + k);
      do_pop();
    end
    check("R9 lost char absent", data_avail, 0);
    send(9'h056, 0, 1);
    check("R9 discard while flagged", data_avail, 0);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0; @(negedge clk);
    check("R9 cleared", overrun, 0);
    send(9'h057, 0, 1);
    check("R9 resumes", rd_data, 9'h057);
    do_pop();
    irq_mode = 2'b00;
  endtask

  task automatic t_ferr();
    send(9'h06E, 0, 0);
    check("R10 stored", data_avail, 1);
    check("R10 data", rd_data, 9'h06E);
    check("R10 ferr set", rd_ferr, 1);
    do_pop();
    check("R10 single char", data_avail, 0);
  endtask

  task automatic t_addr();
    int base;
    nine_bit_en = 1; addr_det_en = 1;
    base = irq_cnt;
    send(9'h055, 1, 1);
    check("R7 data dropped", data_avail, 0);
    check("R7 no irq on drop", irq_cnt - base, 0);
    send(9'h1AA, 1, 1);
    check("R7 address stored", rd_data, 9'h1AA);
    send(9'h033, 1, 1);
    do_pop();
    check("R7 data after address", rd_data, 9'h033);
    do_pop();
    nine_bit_en = 0;
    @(negedge clk);
    send(9'h044, 0, 1);
    check("R8 filter off in 8-bit", rd_data, 9'h044);
    check("R8 stored", data_avail, 1);
    do_pop();
    nine_bit_en = 1;
    @(negedge clk);
    send(9'h077, 1, 1);
    check("R7 filter rearmed", data_avail, 0);
    nine_bit_en = 0; addr_det_en = 0;
  endtask

  task automatic t_glitch();
    hold(1'b0, 8);
    hold(1'b1, 400);
    check("R2 glitch ignored", data_avail, 0);
    check("R2 back to idle", idle, 1);
  endtask

  initial begin
    rst_n = 0; rxd = 1; nine_bit_en = 0; addr_det_en = 0;
    irq_mode = 2'b00; pop = 0; ovr_clr = 0; idle_mid = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_nine();
    t_mode_three();
    t_full_overrun();
    t_ferr();
    t_addr();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule